// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the stack-frame part of a subroutine call or return for a 32-bit processor, over a single-word memory port with a request/ready handshake. The caller presents the current frame pointer and stack pointer with a one-cycle start pulse. For a call it also presents the call target, the address of the call instruction and whether the call was through a register or used an absolute inline target. For a return it presents only the return command.

A call first reserves two words below the stack pointer: one for the static chain and one for the return address, which is written at the lower of the two. It then pushes the old frame pointer one word lower, and the frame pointer becomes the new stack top. A return reverses this. The stack pointer is taken from the frame pointer, the saved frame pointer and the return PC are read back, and the reserved static-chain word is skipped. When the last access is accepted the block presents the new frame pointer, stack pointer and PC with a one-cycle done pulse.

Top module: `frame_seq`

## Requirements
- R1: On a call, the first access is a write (mem_we_o=1) of the return address to address sp_i-8.
- R2: On a call, the second access is a write of the old frame pointer fp_i to address sp_i-12.
- R3: After a call, fp_o and sp_o both equal sp_i-12 and pc_o equals target_i.
- R4: The return address written on a call is call_pc_i+6 when via_reg_i=0 (absolute inline target) and call_pc_i+2 when via_reg_i=1. All arithmetic wraps modulo 2^32.
- R5: On a return (is_ret_i=1), the first access is a read (mem_we_o=0) at address fp_i, and the word read becomes fp_o.
- R6: On a return, the second access is a read at fp_i+4. The word read becomes pc_o, and sp_o becomes fp_i+12.
- R7: While mem_req_o is high and mem_ready_i is low, the sequencer holds mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o unchanged and does not advance.
- R8: done_o is high for exactly one cycle, the cycle after the clock edge at which the second access sees mem_ready_i high. It is low at all other times.
- R9: A start_i pulse while an operation is in progress is ignored: the addresses, data and results of that operation are unaffected.
- R10: Given word-aligned fp_i and sp_i, every memory address has bits [1:0] equal to 0.
- R11: After reset, mem_req_o and done_o are low and fp_o, sp_o and pc_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| is_ret_i | input | 1 | 1 = return, 0 = call |
| via_reg_i | input | 1 | Call through register (1) or absolute inline target (0) |
| call_pc_i | input | 32 | Address of the call instruction |
| target_i | input | 32 | Call target |
| fp_i | input | 32 | Current frame pointer |
| sp_i | input | 32 | Current stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write enable (1 = store) |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access accepted / read data valid |
| done_o | output | 1 | One-cycle completion pulse |
| fp_o | output | 32 | Updated frame pointer |
| sp_o | output | 32 | Updated stack pointer |
| pc_o | output | 32 | Next PC |

## Verification
The alignment assertion assumes that fp_i and sp_i are word-aligned when start_i is accepted. Every stimulus vector and directed case uses multiples of four for both, including the values that wrap at the top and bottom of the address space. The handshake assertions assume that mem_ready_i is high only while mem_req_o is high. The bench's memory model raises ready only on a cycle where it has seen a request, after a per-vector latency of zero to three cycles.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/frame_seq_fsm.sv
module frame_seq_fsm
  import frame_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  output logic req_o,
  output logic sel1_o,
  output logic busy_o,
  output logic load_o,
  output logic cap0_o,
  output logic cap1_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACC0;
      ST_ACC0: if (ready_i) state_d = ST_ACC1;
      ST_ACC1: if (ready_i) state_d = ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_o  = (state_q == ST_ACC0) || (state_q == ST_ACC1);
  assign sel1_o = (state_q == ST_ACC1);
  assign busy_o = (state_q != ST_IDLE);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign cap0_o = (state_q == ST_ACC0) && ready_i;
  assign cap1_o = (state_q == ST_ACC1) && ready_i;
  assign done_o = (state_q == ST_FIN);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap1_o |=> done_o);
  assert_wait_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i) |=> (req_o && $stable(sel1_o)));
  assert_busy_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: rtl/frame_seq_dp.sv
module frame_seq_dp #(
  parameter int XLEN          = 32,
  parameter int WORD_BYTES    = 4,
  parameter int CHAIN_BYTES   = 8,
  parameter int INL_CALL_LEN  = 6,
  parameter int REG_CALL_LEN  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            cap0_i,
  input  logic            cap1_i,
  input  logic            sel1_i,
  input  logic            req_i,
  input  logic            ready_i,
  input  logic            busy_i,
  input  logic            start_i,
  input  logic            is_ret_i,
  input  logic            via_reg_i,
  input  logic [XLEN-1:0] call_pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic            we_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] wdata_o,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] WORD_OFF  = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] CHAIN_OFF = XLEN'(CHAIN_BYTES);
  localparam logic [XLEN-1:0] FRAME_OFF = XLEN'(CHAIN_BYTES + WORD_BYTES);
  localparam logic [XLEN-1:0] INL_OFF   = XLEN'(INL_CALL_LEN);
  localparam logic [XLEN-1:0] REG_OFF   = XLEN'(REG_CALL_LEN);
  localparam int ALIGN_W = $clog2(WORD_BYTES);

  logic            ret_q;
  logic [XLEN-1:0] fp_q, sp_q, ra_q, tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_q <= 1'b0;
      fp_q  <= '0;
      sp_q  <= '0;
      ra_q  <= '0;
      tgt_q <= '0;
    end else if (load_i) begin
      ret_q <= is_ret_i;
      fp_q  <= fp_i;
      sp_q  <= sp_i;
      ra_q  <= call_pc_i + (via_reg_i ? REG_OFF : INL_OFF);
      tgt_q <= target_i;
    end
  end

  always_comb begin
    unique case ({ret_q, sel1_i})
      2'b00:   addr_o = sp_q - CHAIN_OFF;
      2'b01:   addr_o = sp_q - FRAME_OFF;
      2'b10:   addr_o = fp_q;
      default: addr_o = fp_q + WORD_OFF;
    endcase
  end

  assign we_o    = ~ret_q;
  assign wdata_o = sel1_i ? fp_q : ra_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_o <= '0;
      sp_o <= '0;
      pc_o <= '0;
    end else if (cap0_i && ret_q) begin
      fp_o <= rdata_i;
    end else if (cap1_i) begin
      if (ret_q) begin
        pc_o <= rdata_i;
        sp_o <= fp_q + FRAME_OFF;
      end else begin
        fp_o <= sp_q - FRAME_OFF;
        sp_o <= sp_q - FRAME_OFF;
        pc_o <= tgt_q;
      end
    end
  end

  assert_addr_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (addr_o[ALIGN_W-1:0] == '0));
  assert_hold_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_i) |=> ($stable(addr_o) && $stable(we_o) && $stable(wdata_o)));
  assert_ignore_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> ($stable(fp_q) && $stable(sp_q) && $stable(ra_q) && $stable(ret_q)));
  assert_call_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap1_i && !ret_q) |=> (fp_o == sp_o));
  assert_ret_sp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap1_i && ret_q) |=> (sp_o == $past(addr_o) + CHAIN_OFF));
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int XLEN         = 32,
  parameter int WORD_BYTES   = 4,
  parameter int CHAIN_BYTES  = 8,
  parameter int INL_CALL_LEN = 6,
  parameter int REG_CALL_LEN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_ret_i,
  input  logic            via_reg_i,
  input  logic [XLEN-1:0] call_pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_ready_i,
  output logic            done_o,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o
);
  logic sel1, busy, load, cap0, cap1;

  frame_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ready_i (mem_ready_i),
    .req_o   (mem_req_o),
    .sel1_o  (sel1),
    .busy_o  (busy),
    .load_o  (load),
    .cap0_o  (cap0),
    .cap1_o  (cap1),
    .done_o  (done_o)
  );

  frame_seq_dp #(
    .XLEN         (XLEN),
    .WORD_BYTES   (WORD_BYTES),
    .CHAIN_BYTES  (CHAIN_BYTES),
    .INL_CALL_LEN (INL_CALL_LEN),
    .REG_CALL_LEN (REG_CALL_LEN)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .cap0_i    (cap0),
    .cap1_i    (cap1),
    .sel1_i    (sel1),
    .req_i     (mem_req_o),
    .ready_i   (mem_ready_i),
    .busy_i    (busy),
    .start_i   (start_i),
    .is_ret_i  (is_ret_i),
    .via_reg_i (via_reg_i),
    .call_pc_i (call_pc_i),
    .target_i  (target_i),
    .fp_i      (fp_i),
    .sp_i      (sp_i),
    .rdata_i   (mem_rdata_i),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .fp_o      (fp_o),
    .sp_o      (sp_o),
    .pc_o      (pc_o)
  );
endmodule

// File: tb/frame_seq_tb_top.sv
`timescale 1ns/1ps
module frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, is_ret_i = 1'b0, via_reg_i = 1'b0;
  logic [31:0] call_pc_i = '0, target_i = '0, fp_i = '0, sp_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0, fp_o, sp_o, pc_o;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  frame_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .is_ret_i(is_ret_i),
    .via_reg_i(via_reg_i), .call_pc_i(call_pc_i), .target_i(target_i),
    .fp_i(fp_i), .sp_i(sp_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ready_i(mem_ready_i), .done_o(done_o), .fp_o(fp_o), .sp_o(sp_o), .pc_o(pc_o)
  );

  localparam int NV = 6;
  localparam logic        V_RET [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic        V_VIA [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] V_PC  [NV] = '{32'h0000_1000, 32'h0000_1234, 32'h0, 32'h0, 32'hFFFF_FFFE, 32'h0};
  localparam logic [31:0] V_TGT [NV] = '{32'h0000_2000, 32'h4000_0000, 32'h0, 32'h0, 32'h0000_0040, 32'h0};
  localparam logic [31:0] V_FP  [NV] = '{32'h0000_8000, 32'h0000_0100, 32'h0000_7FE4, 32'h0000_0010, 32'h0, 32'hFFFF_FFF8};
  localparam logic [31:0] V_SP  [NV] = '{32'h0000_7FF0, 32'h0000_00F0, 32'h0000_7FE4, 32'h0000_0010, 32'h0000_0004, 32'h0};
  localparam logic [31:0] V_RD0 [NV] = '{32'h0, 32'h0, 32'h0000_8000, 32'hFFFF_FFFC, 32'h0, 32'h0000_0200};
  localparam logic [31:0] V_RD1 [NV] = '{32'h0, 32'h0, 32'h0000_1006, 32'hDEAD_BEEF, 32'h0, 32'h1234_5678};
  localparam int          V_LAT [NV] = '{0, 2, 1, 0, 3, 2};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic ret, input logic via, input logic [31:0] pc, input logic [31:0] tgt,
                        input logic [31:0] fp, input logic [31:0] sp, input logic [31:0] rd0,
                        input logic [31:0] rd1, input int lat, input bit inject);
    logic [31:0] ea [2];
    logic [31:0] ed [2];
    logic [31:0] rd [2];
    logic [31:0] efp, esp, epc;
    rd[0] = rd0; rd[1] = rd1;
    if (!ret) begin
      ea[0] = sp - 32'd8;  ed[0] = pc + (via ? 32'd2 : 32'd6);
      ea[1] = sp - 32'd12; ed[1] = fp;
      efp = sp - 32'd12; esp = sp - 32'd12; epc = tgt;
    end else begin
      ea[0] = fp; ea[1] = fp + 32'd4; ed[0] = '0; ed[1] = '0;
      efp = rd0; esp = fp + 32'd12; epc = rd1;
    end
    is_ret_i = ret; via_reg_i = via; call_pc_i = pc; target_i = tgt; fp_i = fp; sp_i = sp;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      for (int w = 0; w <= lat; w++) begin
        chk(mem_req_o === 1'b1, "R7 req held", 32'(mem_req_o), 32'd1);
        chk(mem_addr_o === ea[k], ret ? (k == 0 ? "R5 addr" : "R6 addr") : (k == 0 ? "R1 addr" : "R2 addr"),
            mem_addr_o, ea[k]);
        chk(mem_we_o === !ret, ret ? "R5 we" : "R1 we", 32'(mem_we_o), 32'(!ret));
        if (!ret) chk(mem_wdata_o === ed[k], k == 0 ? "R4 ra data" : "R2 fp data", mem_wdata_o, ed[k]);
        chk(mem_addr_o[1:0] === 2'b00, "R10 align", 32'(mem_addr_o[1:0]), 32'd0);
        chk(done_o === 1'b0, "R8 early done", 32'(done_o), 32'd0);
        if (inject && k == 0 && w == 0) begin
          start_i = 1'b1; is_ret_i = ~ret; fp_i = 32'h0000_0C00; sp_i = 32'h0000_0A00;
          call_pc_i = 32'h5555_5550; target_i = 32'h7777_0000;
        end
        mem_ready_i = (w == lat);
        mem_rdata_i = (w == lat) ? rd[k] : 32'hA5A5_A5A5;
        @(negedge clk);
        mem_ready_i = 1'b0;
        mem_rdata_i = '0;
        start_i = 1'b0;
      end
    end
    chk(done_o === 1'b1, "R8 done", 32'(done_o), 32'd1);
    chk(mem_req_o === 1'b0, "R8 no req at done", 32'(mem_req_o), 32'd0);
    chk(fp_o === efp, ret ? "R5 fp_o" : "R3 fp_o", fp_o, efp);
    chk(sp_o === esp, ret ? "R6 sp_o" : "R3 sp_o", sp_o, esp);
    chk(pc_o === epc, ret ? "R6 pc_o" : "R3 pc_o", pc_o, epc);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 single pulse", 32'(done_o), 32'd0);
    chk(mem_req_o === 1'b0, "R8 idle after done", 32'(mem_req_o), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mem_req_o === 1'b0, "R11 req", 32'(mem_req_o), 32'd0);
    chk(done_o === 1'b0, "R11 done", 32'(done_o), 32'd0);
    chk(fp_o === 32'd0, "R11 fp_o", fp_o, 32'd0);
    chk(sp_o === 32'd0, "R11 sp_o", sp_o, 32'd0);
    chk(pc_o === 32'd0, "R11 pc_o", pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_o === 1'b0, "R11 idle without start", 32'(mem_req_o), 32'd0);

    for (int i = 0; i < NV; i++)
      run_op(V_RET[i], V_VIA[i], V_PC[i], V_TGT[i], V_FP[i], V_SP[i], V_RD0[i], V_RD1[i], V_LAT[i], 1'b0);

    // R9: start pulses during a call and a return with waits
    run_op(1'b0, 1'b1, 32'h0000_3000, 32'h0000_3400, 32'h0000_9000, 32'h0000_8F00, '0, '0, 2, 1'b1);
    run_op(1'b1, 1'b0, 32'h0, 32'h0, 32'h0000_8EF4, 32'h0000_8EF4, 32'h0000_9000, 32'h0000_3002, 1'b1 ? 3 : 0, 1'b1);

    // R4: back-to-back calls differing only in call form
    run_op(1'b0, 1'b0, 32'h0000_0100, 32'h0000_0200, 32'h0000_0400, 32'h0000_0400, '0, '0, 0, 1'b0);
    run_op(1'b0, 1'b1, 32'h0000_0100, 32'h0000_0200, 32'h0000_0400, 32'h0000_0400, '0, '0, 0, 1'b0);

    // R11: reset mid-operation clears state
    is_ret_i = 1'b0; fp_i = 32'h40; sp_i = 32'h80; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_req_o === 1'b0, "R11 req after reset", 32'(mem_req_o), 32'd0);
    chk(pc_o === 32'd0, "R11 pc after reset", pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule